// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block collects event indications from a serial bus controller's transmit and receive queues and its transaction engine into one 32-bit raw status word. A host-programmed enable word selects which of those events may raise the single interrupt line. The host reads the raw word and the enabled (masked) word separately, and acknowledges events by writing ones into an acknowledge register.

Event positions follow a fixed, sparse map. Queue fill-level indications (bits 0-2 and 4-6) are sampled live every cycle. All other mapped events are sticky and stay set until acknowledged. Unmapped positions, including the top three bits, are held at zero throughout. The host sees four word registers selected by a 2-bit word index. Writes take effect on the clock edge on which they are presented. Reads return data one cycle after the request.

Top module: `isc_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the enable word and raw status are zero, every register reads zero and `irq` is low.
- R2: A sticky event input (bits 3, 16, 17, 18, 19, 20, 24, 25, 28) that is high on a clock edge sets its raw bit from that edge on, and the bit stays set after the input drops.
- R3: Level event bits 0, 1, 2, 4, 5 and 6 of the raw word equal their input as sampled on the previous clock edge, and an acknowledge write does not change them.
- R4: A write to word index 3 (acknowledge) clears each sticky raw bit whose write-data bit is 1. Bits written 0 are left unchanged. Only bits within 0x131F007F are affected.
- R5: When a sticky event input is high on the same edge as an acknowledge write of that bit, the bit stays set.
- R6: Word index 0 (enable) stores only the mapped bits 0x131F007F. All other bits, including 31:29, read as zero.
- R7: Word index 2 reads the raw word ANDed with the enable word.
- R8: `irq` is high exactly when the masked word is non-zero.
- R9: Word index 3 always reads zero. Writes to word index 1 (raw) and word index 2 (masked) change no state.
- R10: Event inputs at unmapped bit positions never set a raw bit. Those raw bits read zero.
- R11: A read request on a clock edge places the selected register's value from that edge on `rd_data` after the edge, and `rd_data` holds it until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_in | input | 32 | Event inputs: live flags for level bits, pulses for sticky bits |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word index: 0 enable, 1 raw, 2 masked, 3 acknowledge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Interrupt line, OR of the masked word |

## Verification
An event or acknowledge write presented on one edge changes the raw word, the masked word and `irq` right after that edge. The value then becomes visible through a read issued on the following edge, which lands on `rd_data` one more edge later. The bench drives every stimulus just after a falling edge. It samples `irq` at the next falling edge, and reads each register through a request whose result it takes one falling edge after the request. This places each comparison exactly one rising edge behind the change that produces it. The single-bit sweep covers all 32 event positions, and the enable sweep covers all 32 mask positions.

// File: rtl/isc_pkg.sv
package isc_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 2;

    // Positions that carry an event at all, and which of those are level-type.
    localparam logic [REG_W-1:0] EVT_MAP    = 32'h131F_007F;
    localparam logic [REG_W-1:0] LEVEL_MAP  = 32'h0000_0077;
    localparam logic [REG_W-1:0] STICKY_MAP = EVT_MAP & ~LEVEL_MAP;
    localparam logic [REG_W-1:0] ACK_MAP    = 32'h131F_007F;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ENABLE = 2'd0,
        SEL_RAW    = 2'd1,
        SEL_MASKED = 2'd2,
        SEL_ACK    = 2'd3
    } isc_sel_e;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'd0,
        KIND_LEVEL  = 2'd1,
        KIND_STICKY = 2'd2
    } isc_kind_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        isc_sel_e         sel;
        logic [REG_W-1:0] data;
    } isc_req_t;

    function automatic isc_kind_e kind_of(input int pos);
        if (LEVEL_MAP[pos])       return KIND_LEVEL;
        else if (STICKY_MAP[pos]) return KIND_STICKY;
        else                      return KIND_NONE;
    endfunction

    function automatic logic [REG_W-1:0] ack_vector(input isc_req_t req);
        if (req.wr && req.sel == SEL_ACK) return req.data & ACK_MAP;
        else                              return '0;
    endfunction

endpackage

// File: rtl/isc_evt_cell.sv
module isc_evt_cell
    import isc_pkg::*;
#(
    parameter isc_kind_e KIND = KIND_NONE
) (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic ack,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            case (KIND)
                KIND_LEVEL:  q <= src;
                // a new event outranks an acknowledge on the same edge
                KIND_STICKY: q <= src | (q & ~ack);
                default:     q <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/isc_evt_bank.sv
module isc_evt_bank
    import isc_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src,
    input  logic [W-1:0] ack,
    output logic [W-1:0] raw
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        localparam isc_kind_e BIT_KIND = kind_of(b);
        isc_evt_cell #(.KIND(BIT_KIND)) u_cell (
            .clk (clk),
            .rst (rst),
            .src (src[b]),
            .ack (ack[b]),
            .q   (raw[b])
        );
    end

endmodule

// File: rtl/isc_host_port.sv
module isc_host_port
    import isc_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  isc_req_t     req,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] masked,
    output logic [W-1:0] enable,
    output logic [W-1:0] ack,
    output logic [W-1:0] rd_data
);

    logic [W-1:0] rd_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
        end else if (req.wr && req.sel == SEL_ENABLE) begin
            enable <= req.data & EVT_MAP;
        end
    end

    assign ack = ack_vector(req);

    always_comb begin
        case (req.sel)
            SEL_ENABLE: rd_next = enable;
            SEL_RAW:    rd_next = raw;
            SEL_MASKED: rd_next = masked;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (req.rd) begin
            rd_data <= rd_next;
        end
    end

endmodule

// File: rtl/isc_irq_tree.sv
module isc_irq_tree
    import isc_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] enable,
    output logic [W-1:0] masked,
    output logic         irq
);

    assign masked = raw & enable;
    assign irq    = |masked;

endmodule

// File: rtl/isc_irq_ctrl.sv
module isc_irq_ctrl
    import isc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  evt_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq
);

    isc_req_t         req;
    logic [REG_W-1:0] raw_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] masked_w;
    logic [REG_W-1:0] ack_w;

    always_comb begin
        req.wr   = wr_en;
        req.rd   = rd_en;
        req.sel  = isc_sel_e'(addr);
        req.data = wr_data;
    end

    isc_evt_bank #(.W(REG_W)) u_bank (
        .clk (clk),
        .rst (rst),
        .src (evt_in),
        .ack (ack_w),
        .raw (raw_q)
    );

    isc_host_port #(.W(REG_W)) u_port (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .raw     (raw_q),
        .masked  (masked_w),
        .enable  (mask_q),
        .ack     (ack_w),
        .rd_data (rd_data)
    );

    isc_irq_tree #(.W(REG_W)) u_tree (
        .raw    (raw_q),
        .enable (mask_q),
        .masked (masked_w),
        .irq    (irq)
    );

endmodule

// File: rtl/isc_irq_ctrl_chk.sv
module isc_irq_ctrl_chk
    import isc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [REG_W-1:0]  evt_in,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  rd_data,
    input logic              irq,
    input logic [REG_W-1:0]  raw_q,
    input logic [REG_W-1:0]  mask_q
);

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        ((raw_q | mask_q) & ~EVT_MAP) == '0);

    assert_sticky_set_R2: assert property (@(posedge clk) disable iff (rst)
        (|(evt_in & STICKY_MAP)) |=>
        ((raw_q & $past(evt_in) & STICKY_MAP) == ($past(evt_in) & STICKY_MAP)));

    assert_level_follow_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((raw_q & LEVEL_MAP) == ($past(evt_in) & LEVEL_MAP)));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd3) |=>
        ((raw_q & $past(wr_data & ~evt_in) & STICKY_MAP) == '0));

    assert_enable_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == 2'd0) |=> $stable(mask_q));

    assert_irq_matches_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd2) |=> ((rd_data != '0) == $past(irq)));

    assert_ack_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 2'd3) |=> (rd_data == '0));

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

bind isc_irq_ctrl isc_irq_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .evt_in  (evt_in),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq     (irq),
    .raw_q   (raw_q),
    .mask_q  (mask_q)
);

// File: tb/isc_irq_ctrl_test.sv
module isc_irq_ctrl_test;

    localparam logic [31:0] MAPPED = 32'h131F_007F;
    localparam logic [31:0] LEVEL  = 32'h0000_0077;
    localparam logic [31:0] STICKY = MAPPED & ~LEVEL;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt_in = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    isc_irq_ctrl uut (
        .clk     (clk),
        .rst     (rst),
        .evt_in  (evt_in),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic pulse(input logic [31:0] v);
        @(negedge clk);
        evt_in = v;
        @(negedge clk);
        evt_in = '0;
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !finished) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] raw_exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            read_reg(a[1:0], v);
            check("R1 reg", v, 32'd0);
        end

        // R6: enable keeps only mapped bits
        write_reg(2'd0, 32'hFFFF_FFFF);
        read_reg(2'd0, v);
        check("R6 enable", v, MAPPED);

        // R2 R3 R10 R4 R8: single-bit sweep over every position
        for (int i = 0; i < 32; i++) begin
            logic [31:0] b;
            b = 32'd1 << i;
            @(negedge clk);
            evt_in = b;
            @(negedge clk);
            check("R8 irq held", {31'd0, irq}, {31'd0, |(b & MAPPED)});
            read_reg(2'd1, v);
            check("R2 R10 raw held", v, b & MAPPED);
            @(negedge clk);
            evt_in = '0;
            read_reg(2'd1, v);
            check("R2 R3 raw released", v, b & STICKY);
            write_reg(2'd3, b);
            read_reg(2'd1, v);
            check("R4 raw acked", v, 32'd0);
        end

        // R5: event and acknowledge on the same edge
        pulse(STICKY);
        @(negedge clk);
        evt_in = 32'h0108_0000;
        wr_en = 1'b1; addr = 2'd3; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        evt_in = '0; wr_en = 1'b0; wr_data = '0;
        read_reg(2'd1, v);
        check("R5 set wins", v, 32'h0108_0000);
        write_reg(2'd3, 32'hFFFF_FFFF);

        // R4: partial acknowledge
        pulse(STICKY);
        write_reg(2'd3, 32'h0300_0008);
        raw_exp = STICKY & ~32'h0300_0008;
        read_reg(2'd1, v);
        check("R4 partial", v, raw_exp);

        // R7 R8: enable sweep over every position
        for (int i = 0; i < 32; i++) begin
            logic [31:0] m;
            m = 32'd1 << i;
            write_reg(2'd0, m);
            check("R8 irq mask", {31'd0, irq}, {31'd0, |(m & raw_exp)});
            read_reg(2'd2, v);
            check("R7 masked", v, m & raw_exp);
        end

        // R9: writes to raw and masked ignored, ack reads zero
        write_reg(2'd0, 32'hFFFF_FFFF);
        write_reg(2'd1, 32'hFFFF_FFFF);
        write_reg(2'd2, 32'hFFFF_FFFF);
        read_reg(2'd1, v);
        check("R9 raw unchanged", v, raw_exp);
        read_reg(2'd3, v);
        check("R9 ack reads zero", v, 32'd0);

        // R3: acknowledge does not drop a held level bit
        @(negedge clk);
        evt_in = 32'h0000_0070;
        write_reg(2'd3, 32'h0000_007F);
        read_reg(2'd1, v);
        check("R3 level vs ack", v, raw_exp | 32'h0000_0070);
        @(negedge clk);
        evt_in = '0;

        // R11: read data holds without a request
        read_reg(2'd0, v);
        repeat (3) @(negedge clk);
        check("R11 hold", rd_data, MAPPED);

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq after reset", {31'd0, irq}, 32'd0);
        read_reg(2'd1, v);
        check("R1 raw after reset", v, 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule